// File: doc/BRIEF.md
# Flag Pin Interrupt Detector

This block manages a bank of general-purpose flag pins. Software chooses, pin by pin, whether the pin is driven by the chip or read from outside. For an input pin, software also chooses how it raises an interrupt: by its level, by one edge of a chosen polarity, or by every transition. Pin samples pass through a two-stage synchronizer before they are examined. Edge events latch into a status bit that holds until software clears it by writing a 1. A level-mode pin's status bit follows the synchronized pin directly.

Software can also set status bits by writing to them. This gives a software interrupt on any pin, including a pin set as an output. Two shared interrupt lines, A and B, each OR together the status bits of the pins enabled for that line. A pin can feed either line, both lines, or neither.

Configuration is written through a simple write port: strobe, 4-bit address and one data bit per pin. Writes take effect on the clock edge that samples the strobe. The detector is built from a per-pin decode with three sensing modes (level, single edge, dual edge) selected by `unique case`. It has no sequencing state beyond its registers.

Top module: `pflag_irq_ctrl`

## Requirements
- R1: After reset every register is zero, and pin_oe, pin_out, status_o, irq_a and irq_b are all zero.
- R2: A write to address 0 loads the direction register, which drives pin_oe (1 = output). A write to address 1 loads the output-data register, which drives pin_out.
- R3: A pin value that is stable before clock edge k appears in status_o after edge k+1 for a level-mode input, and is first compared against its previous sample after edge k+1. A single-stage path would respond one edge early.
- R4: With edge register bit (address 2) at 0, the pin is level-sensitive. Its status bit equals the synchronized pin XOR the invert bit (address 4; 0 = active high). It is not latched, and a clear write does not affect it.
- R5: With edge bit 1 and dual bit (address 3) 0, one edge sets the status bit: rising when the invert bit is 0, falling when it is 1. The opposite edge does nothing.
- R6: With edge bit 1 and dual bit 1, every transition of the synchronized pin sets the status bit.
- R7: An edge-set status bit stays at 1 until a write to address 7 has a 1 in that bit position. Zero bits in that write leave their status bits unchanged.
- R8: A write to address 8 sets the status bits where the data has a 1. This applies to every pin, whatever its direction or mode.
- R9: A pin whose direction bit is 1 produces no hardware event, in either level or edge mode.
- R10: irq_a is the OR of status_o AND the A-enable register (address 5). irq_b is the same with the B-enable register (address 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | NUM_PINS | Raw pin values from the pads |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | NUM_PINS | Write data, one bit per pin |
| pin_oe | output | NUM_PINS | Direction register (1 = drive pin) |
| pin_out | output | NUM_PINS | Output data register |
| status_o | output | NUM_PINS | Per-pin interrupt status |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
The bench checks the exact latency through the synchronizer. A design with one stage too few or too many would fire a cycle early or late, and the bench checks both cycles around the expected one. It checks the polarity of single-edge detection, which a swapped comparison would invert. It checks that a clear write leaves level-mode pins alone and clears only the bits written as 1. It checks that output pins stay quiet when toggled, while a software set still reaches them. A cycle-accurate model runs alongside and compares every output on every clock, so a wrong enable mapping onto line A or B is also detected.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    typedef enum logic [3:0] {
        REG_DIR   = 4'd0,
        REG_DOUT  = 4'd1,
        REG_EDGE  = 4'd2,
        REG_DUAL  = 4'd3,
        REG_INV   = 4'd4,
        REG_ENA   = 4'd5,
        REG_ENB   = 4'd6,
        REG_CLR   = 4'd7,
        REG_SWSET = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        SENSE_LEVEL    = 2'd0,
        SENSE_ONE_EDGE = 2'd1,
        SENSE_TWO_EDGE = 2'd2
    } sense_e;

    function automatic sense_e decode_sense(input logic edge_bit, input logic dual_bit);
        if (!edge_bit)
            return SENSE_LEVEL;
        else if (dual_bit)
            return SENSE_TWO_EDGE;
        else
            return SENSE_ONE_EDGE;
    endfunction

endpackage

// File: rtl/pflag_sync.sv
module pflag_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pflag_detect.sv
module pflag_detect
    import pflag_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_i,
    input  logic [NUM_PINS-1:0] dir_i,
    input  logic [NUM_PINS-1:0] edge_i,
    input  logic [NUM_PINS-1:0] dual_i,
    input  logic [NUM_PINS-1:0] inv_i,
    output logic [NUM_PINS-1:0] evt_o,
    output logic [NUM_PINS-1:0] lvl_o
);
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        sense_e mode;
        logic   ev;
        logic   lv;
        always_comb begin
            mode = decode_sense(edge_i[g], dual_i[g]);
            ev   = 1'b0;
            lv   = 1'b0;
            if (!dir_i[g]) begin
                unique case (mode)
                    SENSE_LEVEL:    lv = sync_i[g] ^ inv_i[g];
                    SENSE_ONE_EDGE: ev = inv_i[g] ? (prev_q[g] & ~sync_i[g])
                                                  : (~prev_q[g] & sync_i[g]);
                    SENSE_TWO_EDGE: ev = prev_q[g] ^ sync_i[g];
                    default:        ev = 1'b0;
                endcase
            end
        end
        assign evt_o[g] = ev;
        assign lvl_o[g] = lv;
    end

    // R5 / R6: an edge event needs a change between successive samples
    a_r5_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o != '0) |-> ((sync_i ^ prev_q) != '0));

endmodule

// File: rtl/pflag_regs.sv
module pflag_regs
    import pflag_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [3:0]          wr_addr,
    input  logic [NUM_PINS-1:0] wr_data,
    input  logic [NUM_PINS-1:0] evt_i,
    output logic [NUM_PINS-1:0] dir_o,
    output logic [NUM_PINS-1:0] dout_o,
    output logic [NUM_PINS-1:0] edge_o,
    output logic [NUM_PINS-1:0] dual_o,
    output logic [NUM_PINS-1:0] inv_o,
    output logic [NUM_PINS-1:0] ena_o,
    output logic [NUM_PINS-1:0] enb_o,
    output logic [NUM_PINS-1:0] sticky_o
);
    logic [NUM_PINS-1:0] clr_mask;
    logic [NUM_PINS-1:0] set_mask;

    always_comb begin
        clr_mask = '0;
        set_mask = '0;
        if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                REG_CLR:   clr_mask = wr_data;
                REG_SWSET: set_mask = wr_data;
                default:   clr_mask = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_o  <= '0;
            dout_o <= '0;
            edge_o <= '0;
            dual_o <= '0;
            inv_o  <= '0;
            ena_o  <= '0;
            enb_o  <= '0;
        end else if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                REG_DIR:  dir_o  <= wr_data;
                REG_DOUT: dout_o <= wr_data;
                REG_EDGE: edge_o <= wr_data;
                REG_DUAL: dual_o <= wr_data;
                REG_INV:  inv_o  <= wr_data;
                REG_ENA:  ena_o  <= wr_data;
                REG_ENB:  enb_o  <= wr_data;
                default:  dir_o  <= dir_o;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_o <= '0;
        else        sticky_o <= (sticky_o & ~clr_mask) | evt_i | set_mask;
    end

    // R7: a latched bit only drops when a clear write named it
    a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sticky_o & $past(sticky_o) & ~$past(clr_mask)) == '0));

    // R8: a software set always lands
    a_r8_swset_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_mask) & ~sticky_o) == '0));

    // R9: a bit of an output pin only rises through software
    a_r9_output_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky_o & ~$past(sticky_o) & $past(dir_o) & ~$past(set_mask)) == '0));

endmodule

// File: rtl/pflag_irq_ctrl.sv
module pflag_irq_ctrl
    import pflag_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                wr_en,
    input  logic [3:0]          wr_addr,
    input  logic [NUM_PINS-1:0] wr_data,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] status_o,
    output logic                irq_a,
    output logic                irq_b
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] dir_q, dout_q, edge_q, dual_q, inv_q, ena_q, enb_q, sticky_q;
    logic [NUM_PINS-1:0] evt, lvl;

    pflag_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(pin_sync)
    );

    pflag_detect #(.NUM_PINS(NUM_PINS)) i_detect (
        .clk(clk), .rst_n(rst_n), .sync_i(pin_sync), .dir_i(dir_q),
        .edge_i(edge_q), .dual_i(dual_q), .inv_i(inv_q),
        .evt_o(evt), .lvl_o(lvl)
    );

    pflag_regs #(.NUM_PINS(NUM_PINS)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_i(evt), .dir_o(dir_q), .dout_o(dout_q),
        .edge_o(edge_q), .dual_o(dual_q), .inv_o(inv_q), .ena_o(ena_q),
        .enb_o(enb_q), .sticky_o(sticky_q)
    );

    always_comb begin
        pin_oe   = dir_q;
        pin_out  = dout_q;
        status_o = sticky_q | lvl;
        irq_a    = |(status_o & ena_q);
        irq_b    = |(status_o & enb_q);
    end

    // R10: a raised line always has a status bit behind it
    a_r10_irq_a_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |-> (status_o != '0));
    a_r10_irq_b_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b |-> (status_o != '0));
    // R9: level-mode output pins never show status through the level path
    a_r9_no_level_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl & pin_oe) == '0));

endmodule

// File: tb/test_pflag_irq_ctrl.sv
module test_pflag_irq_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] pin_oe, pin_out, status_o;
    logic         irq_a, irq_b;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pflag_irq_ctrl #(.NUM_PINS(N)) i_pflag_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pin_oe(pin_oe),
        .pin_out(pin_out), .status_o(status_o), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [N-1:0] m_s1, m_s2, m_prev, m_dir, m_dout, m_edge, m_dual, m_inv, m_ena, m_enb, m_st;
    logic [N-1:0] m_ev, m_clr, m_sw, m_status;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_dir = '0; m_dout = '0; m_edge = '0;
            m_dual = '0; m_inv = '0; m_ena = '0; m_enb = '0; m_st = '0;
        end else begin
            m_ev = '0;
            for (int i = 0; i < N; i++) begin
                if (!m_dir[i] && m_edge[i]) begin
                    if (m_dual[i])     m_ev[i] = m_s2[i] != m_prev[i];
                    else if (m_inv[i]) m_ev[i] = m_prev[i] && !m_s2[i];
                    else               m_ev[i] = !m_prev[i] && m_s2[i];
                end
            end
            m_clr = (wr_en && wr_addr == 4'd7) ? wr_data : '0;
            m_sw  = (wr_en && wr_addr == 4'd8) ? wr_data : '0;
            m_st  = (m_st & ~m_clr) | m_ev | m_sw;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_dir  = wr_data;
                    4'd1: m_dout = wr_data;
                    4'd2: m_edge = wr_data;
                    4'd3: m_dual = wr_data;
                    4'd4: m_inv  = wr_data;
                    4'd5: m_ena  = wr_data;
                    4'd6: m_enb  = wr_data;
                    default: ;
                endcase
            end
        end
        #1;
        m_status = m_st | (~m_dir & ~m_edge & (m_s2 ^ m_inv));
        check("R2 model pin_oe", pin_oe, m_dir);
        check("R2 model pin_out", pin_out, m_dout);
        check("R3 model status", status_o, m_status);
        check("R10 model irq_a", {7'd0, irq_a}, {7'd0, |(m_status & m_ena)});
        check("R10 model irq_b", {7'd0, irq_b}, {7'd0, |(m_status & m_enb)});
    end

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpins(input logic [N-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R1 status", status_o, '0);
        check("R1 oe", pin_oe, '0);
        check("R1 irq", {6'd0, irq_a, irq_b}, '0);

        wr(4'd0, 8'hF0); wr(4'd1, 8'hA0);
        check("R2 oe", pin_oe, 8'hF0);
        check("R2 out", pin_out, 8'hA0);
        wr(4'd0, 8'h00);

        setpins(8'h04);
        @(posedge clk); #1 check("R3 one edge early", status_o & 8'h04, 8'h00);
        @(posedge clk); #1 check("R3 after two edges", status_o & 8'h04, 8'h04);

        wr(4'd4, 8'h02);
        setpins(8'h03); idle(3);
        check("R4 level polarity", status_o, 8'h01);
        wr(4'd7, 8'hFF); idle(1);
        check("R4 clear ignores level", status_o, 8'h01);
        setpins(8'h00); idle(3);
        check("R4 active-low level", status_o, 8'h02);

        wr(4'd2, 8'h0F); wr(4'd7, 8'hFF); idle(2);
        check("R5 idle after mode change", status_o, 8'h00);
        setpins(8'h03); idle(4);
        check("R5 rising only on bit0", status_o, 8'h01);
        setpins(8'h00); idle(4);
        check("R5 falling on bit1", status_o, 8'h03);
        wr(4'd7, 8'h01); idle(1);
        check("R7 clear one bit", status_o, 8'h02);
        wr(4'd7, 8'h00); idle(3);
        check("R7 zero write keeps", status_o, 8'h02);

        wr(4'd3, 8'h04); wr(4'd7, 8'hFF); idle(1);
        check("R6 cleared", status_o, 8'h00);
        setpins(8'h04); idle(4);
        check("R6 rise", status_o, 8'h04);
        wr(4'd7, 8'h04); idle(1);
        setpins(8'h00); idle(4);
        check("R6 fall", status_o, 8'h04);
        wr(4'd7, 8'hFF);

        wr(4'd0, 8'hF0); wr(4'd2, 8'hFF); wr(4'd3, 8'hF0); wr(4'd7, 8'hFF);
        setpins(8'hF0); idle(4);
        check("R9 no edge on outputs", status_o, 8'h00);
        wr(4'd2, 8'h0F); idle(3);
        check("R9 no level on outputs", status_o, 8'h00);
        setpins(8'h00); idle(4);
        check("R9 still quiet", status_o, 8'h00);

        wr(4'd8, 8'h80); idle(1);
        check("R8 swset output pin", status_o, 8'h80);
        wr(4'd8, 8'h01); idle(1);
        check("R8 swset input pin", status_o, 8'h81);

        wr(4'd5, 8'h01); wr(4'd6, 8'h80); idle(1);
        check("R10 both lines", {6'd0, irq_a, irq_b}, 8'h03);
        wr(4'd7, 8'h01); idle(1);
        check("R10 only B", {6'd0, irq_a, irq_b}, 8'h01);
        wr(4'd7, 8'h80); idle(1);
        check("R10 none", {6'd0, irq_a, irq_b}, 8'h00);

        wr(4'd0, 8'h00); wr(4'd2, 8'h00); wr(4'd3, 8'h00); wr(4'd4, 8'h00);
        setpins(8'h01); idle(3);
        check("R10 level drives A", {6'd0, irq_a, irq_b}, 8'h02);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule